// File: doc/BRIEF.md
# Transition-Signalled Micropipeline FIFO

This block is a first-in first-out pipeline of identical stages that pass data words forward using two-phase handshaking. A request or an acknowledge is an event carried by a change of level on a wire, and a change in either direction counts. Each stage pairs a word register with a Muller C-element. One input of the C-element is the request arriving from upstream. The other is the inverse of the completion signal coming back from the stage downstream. Every change of the C-element output captures one word. After a fixed delay, the same change appears as the stage's completion signal. That completion signal is both the request to the next stage and the acknowledge to the previous one.

The pipeline is written as synchronous logic, driven by a fast sampling clock. One clock edge evaluates each C-element, and the completion delay is a chain of flops, so every handshake event costs a known number of cycles. The upstream sender toggles `in_req` after it places a word on `in_data`. It must hold that word until `in_ack` changes to the same level. The downstream receiver sees a word waiting whenever `out_req` differs from `out_ack`, and it takes the word by toggling `out_ack`. The FIFO holds as many words as it has stages.

Top module: `tfifo_pipe`

## Requirements
- R1: During reset and at the first cycle after it, `in_ack`, `out_req` and `out_data` are 0 and every stage is empty.
- R2: When a request toggles into an empty pipeline, `in_ack` takes the new level of `in_req` exactly 1+DELAY cycles later and not earlier.
- R3: A word entered into an empty pipeline while the receiver is idle appears on `out_data`, with `out_req` toggled, exactly DEPTH*(1+DELAY) cycles after the request.
- R4: Words leave in the order they entered, with none lost and none repeated. Rising and falling request transitions both carry a word.
- R5: While `out_req` differs from `out_ack`, `out_data` does not change.
- R6: `in_ack` changes only while a request is pending (`in_req` differs from `in_ack`). `out_req` changes only while the previous word has been acknowledged (`out_req` equals `out_ack`).
- R7: The number of words accepted but not yet taken never exceeds DEPTH. With `out_ack` held, exactly DEPTH requests are acknowledged and the next one waits.
- R8: A stage's enable changes only when both C-element inputs agree on the new level. A request blocked behind a full stage is acknowledged DEPTH*(1+DELAY) cycles after the receiver's `out_ack` toggle frees the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock that evaluates the C-elements and delays |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | WIDTH | Word offered by the sender |
| in_req | input | 1 | Sender request; every level change offers one word |
| in_ack | output | 1 | Acknowledge to sender; completion of the first stage |
| out_data | output | WIDTH | Word held by the last stage |
| out_req | output | 1 | Request to receiver; completion of the last stage |
| out_ack | input | 1 | Receiver acknowledge; every level change takes one word |

## Verification
Suppose a C-element fires on a half-agreement, or a stage register loads outside its enable change. The effect reaches the ports within a few hand-offs. A word is duplicated, dropped or overwritten, and the ordered scoreboard catches this the first time that word should leave. Suppose instead the completion delay or the C-element has the wrong latency. Then the acknowledge and output toggles land on a different cycle from the exact 1+DELAY and DEPTH*(1+DELAY) counts, which are checked in the first directed transfer. A stage that passes a word before its neighbour has emptied shows up as a fourth acknowledge while the output is stalled, or as output data that moves while a word is waiting.

// File: rtl/tfifo_pkg.sv
// Package: shared helpers for the transition-signalled FIFO.
// Assumes nothing beyond single-bit handshake levels.
package tfifo_pkg;

    // Muller C-element next state: follow the inputs when they agree, else keep.
    function automatic logic c_next(input logic a, input logic b, input logic q);
        return (a == b) ? a : q;
    endfunction

endpackage

// File: rtl/tfifo_celem.sv
// Module: registered Muller C-element.
// The output follows both inputs one clock after they agree and holds otherwise.
// 'fire' is high in the cycle before the output changes.
// Assumes the inputs are synchronous to clk.
module tfifo_celem
    import tfifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q,
    output logic fire
);

    // Combinational look-ahead: the output will change at the next edge.
    always_comb begin
        fire = (c_next(a, b, q) != q);
    end

    // State update: agreement sets the output, disagreement holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= c_next(a, b, q);
    end

endmodule

// File: rtl/tfifo_delay.sv
// Module: fixed completion delay of DELAY sampling-clock cycles.
// Assumes DELAY >= 1. Built as a flop chain, so every transition is kept.
module tfifo_delay #(
    parameter int DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (DELAY == 1) begin : g_one
            logic r;
            // Single flop stage.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b0;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [DELAY-1:0] sh;
            // Shift register carrying the enable level forward.
            always_ff @(posedge clk) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[DELAY-2:0], d};
            end
            assign q = sh[DELAY-1];
        end
    endgenerate

endmodule

// File: rtl/tfifo_stage.sv
// Module: one pipeline stage: C-element enable, word register, completion delay.
// Captures data_in on every change of its enable, whichever direction.
// Assumes upstream holds data_in stable while its request is unacknowledged.
module tfifo_stage #(
    parameter int WIDTH = 8,
    parameter int DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_in,
    input  logic             ack_in,
    input  logic [WIDTH-1:0] data_in,
    output logic             en,
    output logic             done,
    output logic [WIDTH-1:0] data_out
);

    logic fire;
    logic nack;

    assign nack = ~ack_in;

    tfifo_celem u_celem (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (req_in),
        .b     (nack),
        .q     (en),
        .fire  (fire)
    );

    // Word register: loads in the same edge the enable changes.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_out <= '0;
        else if (fire) data_out <= data_in;
    end

    tfifo_delay #(.DELAY(DELAY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (en),
        .q     (done)
    );

endmodule

// File: rtl/tfifo_pipe.sv
// Module: top of the transition-signalled FIFO, DEPTH stages in a chain.
// Stage i takes its request from stage i-1's completion (or in_req) and its
// acknowledge from stage i+1's completion (or out_ack).
// Assumes DEPTH >= 1, DELAY >= 1, and a sender and receiver that obey the
// two-phase protocol.
module tfifo_pipe #(
    parameter int DEPTH = 3,
    parameter int WIDTH = 8,
    parameter int DELAY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_req,
    output logic             in_ack,
    output logic [WIDTH-1:0] out_data,
    output logic             out_req,
    input  logic             out_ack
);

    logic [DEPTH:0]   req_chain;
    logic [DEPTH-1:0] ack_vec;
    logic [DEPTH-1:0] en_vec;
    logic [WIDTH-1:0] dchain [DEPTH+1];

    assign req_chain[0] = in_req;
    assign dchain[0]    = in_data;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == DEPTH - 1) begin : g_last
                assign ack_vec[i] = out_ack;
            end else begin : g_mid
                assign ack_vec[i] = req_chain[i+2];
            end

            tfifo_stage #(.WIDTH(WIDTH), .DELAY(DELAY)) u_stage (
                .clk      (clk),
                .rst_n    (rst_n),
                .req_in   (req_chain[i]),
                .ack_in   (ack_vec[i]),
                .data_in  (dchain[i]),
                .en       (en_vec[i]),
                .done     (req_chain[i+1]),
                .data_out (dchain[i+1])
            );
        end
    endgenerate

    assign in_ack   = req_chain[1];
    assign out_req  = req_chain[DEPTH];
    assign out_data = dchain[DEPTH];

endmodule

// File: rtl/tfifo_pipe_chk.sv
// Module: protocol and capacity checker, bound into tfifo_pipe.
// Assumes sender and receiver follow the two-phase protocol.
module tfifo_pipe_chk #(
    parameter int DEPTH = 3,
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_req,
    input logic             in_ack,
    input logic             out_req,
    input logic             out_ack,
    input logic [WIDTH-1:0] out_data,
    input logic [DEPTH-1:0] req_vec,
    input logic [DEPTH-1:0] ack_vec,
    input logic [DEPTH-1:0] en_vec
);

    int   occ;
    logic prev_in_ack;
    logic prev_out_ack;

    // Occupancy bookkeeping: acknowledged inputs minus taken outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ          <= 0;
            prev_in_ack  <= 1'b0;
            prev_out_ack <= 1'b0;
        end else begin
            occ          <= occ + int'(in_ack != prev_in_ack) - int'(out_ack != prev_out_ack);
            prev_in_ack  <= in_ack;
            prev_out_ack <= out_ack;
        end
    end

    // R1: idle handshake outputs on leaving reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (!in_ack && !out_req && out_data == '0));

    // R5: waiting word is held
    a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req != out_ack) |=> $stable(out_data));

    // R6: acknowledge only answers a pending request
    a_r6_ack_on_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(in_ack) |-> $past(in_req != in_ack));

    // R6: a new output request only after the previous one was taken
    a_r6_req_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_req) |-> $past(out_req == out_ack));

    // R7: never more words inside than stages
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH && occ >= 0);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_c
            // R8: enable moves only to a level both C inputs agreed on
            a_r8_celem_agree: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(en_vec[i]) |-> ($past(req_vec[i]) == en_vec[i] && $past(ack_vec[i]) != en_vec[i]));
        end
    endgenerate

endmodule

bind tfifo_pipe tfifo_pipe_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data),
    .req_vec  (req_chain[DEPTH-1:0]),
    .ack_vec  (ack_vec),
    .en_vec   (en_vec)
);

// File: tb/sim_tfifo_pipe.sv
// Bench: directed timing checks, then a scoreboard stream with random stalls.
module sim_tfifo_pipe;

    localparam int DEPTH   = 3;
    localparam int WIDTH   = 8;
    localparam int DELAY   = 2;
    localparam int LAT_ACK = 1 + DELAY;
    localparam int LAT_OUT = DEPTH * (1 + DELAY);
    localparam int NWORDS  = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [WIDTH-1:0] in_data = '0;
    logic             in_req = 1'b0;
    logic             in_ack;
    logic [WIDTH-1:0] out_data;
    logic             out_req;
    logic             out_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int rx_cnt = 0;
    bit stop_mon = 0;
    bit finished = 0;
    logic [WIDTH-1:0] exp_q [$];

    always #10 clk = ~clk;

    tfifo_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH), .DELAY(DELAY)) u0 (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_req(in_req),
        .in_ack(in_ack), .out_data(out_data), .out_req(out_req), .out_ack(out_ack)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: offer one word, record it, wait for its acknowledge.
    task automatic send(input logic [WIDTH-1:0] w);
        @(negedge clk);
        in_data = w;
        exp_q.push_back(w);
        in_req = ~in_req;
        while (in_ack != in_req) @(negedge clk);
    endtask

    // Manual receive: wait for a word, compare, acknowledge.
    task automatic take(input logic [WIDTH-1:0] w, input string tag);
        while (out_req == out_ack) @(negedge clk);
        chk(out_data == w, tag, out_data, w);
        out_ack = ~out_ack;
        @(negedge clk);
    endtask

    // Timed single transfer into an empty pipe (R2, R3, R4 directions).
    task automatic timed_word(input logic [WIDTH-1:0] w);
        logic new_lvl;
        @(negedge clk);
        in_data = w;
        in_req  = ~in_req;
        new_lvl = in_req;
        for (int j = 1; j <= LAT_OUT; j++) begin
            @(negedge clk);
            if (j == LAT_ACK - 1) chk(in_ack != new_lvl, "R2 ack early", in_ack, !new_lvl);
            if (j == LAT_ACK)     chk(in_ack == new_lvl, "R2 ack latency", in_ack, new_lvl);
            if (j == LAT_OUT - 1) chk(out_req != new_lvl, "R3 out early", out_req, !new_lvl);
        end
        chk(out_req == new_lvl, "R3 out latency", out_req, new_lvl);
        chk(out_data == w, "R4 word value", out_data, w);
        out_ack = ~out_ack;
        repeat (LAT_OUT + 2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(in_ack == 1'b0, "R1 in_ack in reset", in_ack, 0);
        chk(out_req == 1'b0, "R1 out_req in reset", out_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_data == '0, "R1 out_data after reset", out_data, 0);
        chk(in_ack == 1'b0 && out_req == 1'b0, "R1 idle after reset", {in_ack, out_req}, 0);

        // R2 R3: rising transition, then R4: falling transition carries a word too
        timed_word(8'hA5);
        timed_word(8'h3C);

        // R7: capacity with receiver stalled
        exp_q.delete();
        send(8'h11);
        send(8'h22);
        send(8'h33);
        chk(in_ack == in_req, "R7 DEPTH words accepted", in_ack, in_req);
        @(negedge clk);
        in_data = 8'h44;
        in_req  = ~in_req;
        repeat (20) @(negedge clk);
        chk(in_ack != in_req, "R7 extra word held off", in_ack, !in_req);
        // R5: waiting word steady while stalled
        for (int k = 0; k < 4; k++) begin
            chk(out_data == 8'h11, "R5 out_data held", out_data, 8'h11);
            @(negedge clk);
        end
        // R8: blocked request released only after the chain of C-elements clears
        out_ack = ~out_ack;
        for (int j = 1; j <= LAT_OUT; j++) begin
            @(negedge clk);
            if (j == LAT_OUT - 1) chk(in_ack != in_req, "R8 release early", in_ack, !in_req);
        end
        chk(in_ack == in_req, "R8 release latency", in_ack, in_req);
        take(8'h22, "R4 drain order 2");
        take(8'h33, "R4 drain order 3");
        take(8'h44, "R4 drain order 4");
        exp_q.delete();

        // R4: random stream with random receiver stalls, scoreboard compare
        fork
            begin : monitor
                bit stall = 0;
                while (!stop_mon) begin
                    @(negedge clk);
                    if (out_req != out_ack && !stall) begin
                        if (exp_q.size() == 0) begin
                            chk(0, "R4 unexpected word", out_data, 0);
                        end else begin
                            logic [WIDTH-1:0] e;
                            e = exp_q.pop_front();
                            chk(out_data == e, "R4 stream order", out_data, e);
                        end
                        rx_cnt++;
                        out_ack = ~out_ack;
                    end
                    stall = ($urandom % 4) == 0;
                end
            end
        join_none
        for (int n = 0; n < NWORDS; n++) begin
            send(WIDTH'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end
        for (int t = 0; t < 2000 && exp_q.size() != 0; t++) @(negedge clk);
        repeat (LAT_OUT + 5) @(negedge clk);
        stop_mon = 1;
        chk(rx_cnt == NWORDS, "R4 count received", rx_cnt, NWORDS);
        chk(exp_q.size() == 0, "R4 nothing lost", exp_q.size(), 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule